// File: doc/BRIEF.md
# Multiprocessor-Filtering Serial Receiver

This block receives asynchronous serial frames on a single line and writes each data byte into a receive data register that software reads. Each frame has one low start bit, eight data bits, one multiprocessor bit and one high stop bit. Bits are sent least significant bit first and the line idles high. The receiver takes its bit timing from a 16x oversampling tick, and it samples every bit once, at the middle of its sixteen ticks. Software chooses where the tick comes from: an internal divider, or an external clock fed in on the shared serial clock pin. The same selection decides whether that pin is driven out with a bit-rate clock.

On a bus shared by several receivers, software arms an address filter. While the filter is armed, every frame whose multiprocessor bit is 0 is thrown away. Such a frame leaves the data register, the status flags and the interrupt lines untouched. The first frame whose multiprocessor bit is 1 clears the arm bit in hardware and is received like any other frame, so the address byte that follows reaches software. The status outputs are receive-full, framing error, overrun and the last received multiprocessor bit. Each flag has its own clear pulse.

Top module: `mpr_serial_rx`

## Requirements
- R1: When `async_en` is 1, a frame on `rx` (low start, 8 data bits LSB first, multiprocessor bit, high stop, idle high) loads its data byte into `rx_data`, sets `rdrf`, and copies its multiprocessor bit to `mpb`. When `async_en` is 0, the receiver ignores the line and nothing changes.
- R2: The filter drops frames only while `mp_en` and `async_en` are both 1. With `mp_en` at 0, a frame whose multiprocessor bit is 0 is received normally even when `armed` is 1, and `armed` stays 1.
- R3: While the filter is active and `armed` is 1, a frame whose multiprocessor bit is 0 leaves `rx_data`, `rdrf`, `fer`, `orer` and `mpb` unchanged. This holds even when its stop bit is low.
- R4: While the filter is active and `armed` is 1, a frame whose multiprocessor bit is 1 clears `armed`, sets `mpb` to 1 and is received normally. If an `arm_set` pulse arrives in the same cycle, the hardware clear wins.
- R5: `rxi_irq` equals `rx_irq_en` AND `rdrf`. `eri_irq` equals `rx_irq_en` AND (`fer` OR `orer`).
- R6: A received frame whose stop bit samples low sets `fer`. Its data is written to `rx_data`, but `rdrf` is not set. The receiver waits for the line to return high before it looks for the next start bit.
- R7: A received frame that completes while `rdrf` is 1 sets `orer` and leaves `rx_data` unchanged.
- R8: One-cycle pulses on `clr_rdrf`, `clr_fer` and `clr_orer` each clear only their own flag. A one-cycle pulse on `arm_set` sets `armed`.
- R9: With `clk_sel` at 00 or 01, the internal divider supplies one tick every `BAUD_DIV` clocks. With 00, `sck_oe` is 0 and `sck_out` is 0. With 01, `sck_oe` is 1 and `sck_out` is a clock with one period per bit time (16 ticks).
- R10: With `clk_sel[1]` at 1, each rising edge of `sck_in` gives exactly one tick, after a two-flop synchronizer, and `sck_oe` is 0.
- R11: A low pulse on `rx` that is back high before the start-bit midpoint (tick 8) is a false start. It is ignored, and the next frame is received correctly.
- R12: After reset, `rx_data` is 0, all flags, `armed`, `sck_oe` and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| async_en | input | 1 | Enables asynchronous reception |
| mp_en | input | 1 | Multiprocessor mode select |
| arm_set | input | 1 | Pulse that arms the address filter |
| clk_sel | input | 2 | Tick source and serial clock pin mode |
| rx_irq_en | input | 1 | Enable for the receive and error interrupts |
| clr_rdrf | input | 1 | Pulse that clears receive-full |
| clr_fer | input | 1 | Pulse that clears framing error |
| clr_orer | input | 1 | Pulse that clears overrun |
| rx | input | 1 | Serial receive line |
| sck_in | input | 1 | External 16x clock from the serial clock pin |
| sck_out | output | 1 | Bit-rate clock driven to the serial clock pin |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| rx_data | output | 8 | Receive data register |
| rdrf | output | 1 | Receive-full flag |
| fer | output | 1 | Framing error flag |
| orer | output | 1 | Overrun flag |
| mpb | output | 1 | Multiprocessor bit of the last received frame |
| armed | output | 1 | Address filter armed |
| rxi_irq | output | 1 | Receive interrupt |
| eri_irq | output | 1 | Error interrupt |

## Verification
Reception is driven with directed frames and with random frames. The random frames vary the data byte, the multiprocessor bit, the stop-bit level, `mp_en`, the arm pulse and the clear pulses, and a bench model predicts every flag. The tests are chosen so that each one rules out a specific wrong design:
- Dropped frames with a low stop bit show whether the filter really suppresses the framing error, or whether it only suppresses the data transfer.
- A back-to-back frame with no clear in between shows whether overrun protects the data register.
- A short low glitch shows whether the false-start path drops back to idle, or whether it misaligns the next frame.
- Frames sent on the external clock use bits twice as long as the internal rate. Only a receiver that really switched its tick source can decode them.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    localparam int DATA_W   = 8;
    localparam int OVS      = 16;
    localparam int MID_TICK = OVS / 2;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              mpb;
        logic              stop_ok;
    } rx_frame_t;

    typedef struct packed {
        logic rdrf;
        logic fer;
        logic orer;
        logic mpb;
    } rx_flags_t;

    function automatic logic sel_external(input logic [1:0] sel);
        return sel[1];
    endfunction

    function automatic logic sel_drives_pin(input logic [1:0] sel);
        return sel == 2'b01;
    endfunction

endpackage

// File: rtl/mpr_tick_src.sv
module mpr_tick_src
    import mpr_pkg::*;
#(
    parameter int BAUD_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] clk_sel,
    input  logic       sck_in,
    output logic       tick,
    output logic       sck_out,
    output logic       sck_oe
);

    localparam int DIV_W = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
    localparam int HB_W  = $clog2(MID_TICK);

    logic [DIV_W-1:0] div_q;
    logic             tick_int;
    logic [2:0]       sck_sync;
    logic             tick_ext;
    logic [HB_W-1:0]  hb_q;
    logic             sck_q;

    // internal divider
    assign tick_int = (div_q == DIV_W'(BAUD_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || tick_int) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // external clock: two-flop synchronizer plus edge detector
    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sync <= 3'b000;
        end else begin
            sck_sync <= {sck_sync[1:0], sck_in};
        end
    end

    assign tick_ext = sck_sync[1] & ~sck_sync[2];

    // bit-rate clock output: toggles every half bit of internal ticks
    always_ff @(posedge clk) begin
        if (rst || !sel_drives_pin(clk_sel)) begin
            hb_q  <= '0;
            sck_q <= 1'b0;
        end else if (tick_int) begin
            hb_q <= hb_q + 1'b1;
            if (hb_q == HB_W'(MID_TICK - 1)) begin
                sck_q <= ~sck_q;
            end
        end
    end

    assign tick    = sel_external(clk_sel) ? tick_ext : tick_int;
    assign sck_out = sck_q;
    assign sck_oe  = sel_drives_pin(clk_sel);

    AST_EXT_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick_ext |=> !tick_ext);                                           // R10

    AST_SCK_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sel_drives_pin(clk_sel) |=> !sck_out);                            // R9

endmodule

// File: rtl/mpr_rx_core.sv
module mpr_rx_core
    import mpr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      tick,
    input  logic      rx,
    output logic      frame_done,
    output rx_frame_t frame
);

    localparam int CNT_W = $clog2(OVS);
    localparam int NBITS = DATA_W + 1;
    localparam int BIT_W = $clog2(NBITS);

    logic [1:0]       rx_sync;
    logic             rx_s;
    rx_state_e        st;
    logic [CNT_W-1:0] cnt;
    logic [BIT_W-1:0] bitn;
    logic [NBITS-1:0] shreg;
    logic             done_q;
    logic             stop_q;
    logic             line_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sync <= 2'b11;
        end else begin
            rx_sync <= {rx_sync[0], rx};
        end
    end

    assign rx_s = rx_sync[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= RX_IDLE;
            cnt     <= '0;
            bitn    <= '0;
            shreg   <= '0;
            done_q  <= 1'b0;
            stop_q  <= 1'b0;
            line_hi <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!enable) begin
                st  <= RX_IDLE;
                cnt <= '0;
            end else if (tick) begin
                unique case (st)
                    RX_IDLE: begin
                        if (rx_s) begin
                            line_hi <= 1'b1;
                        end else if (line_hi) begin
                            st  <= RX_START;
                            cnt <= CNT_W'(1);
                        end
                    end
                    RX_START: begin
                        if (cnt == CNT_W'(MID_TICK - 1)) begin
                            cnt <= '0;
                            if (rx_s) begin
                                st <= RX_IDLE;
                            end else begin
                                st   <= RX_BITS;
                                bitn <= '0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_BITS: begin
                        if (cnt == CNT_W'(OVS - 1)) begin
                            cnt   <= '0;
                            shreg <= {rx_s, shreg[NBITS-1:1]};
                            if (bitn == BIT_W'(NBITS - 1)) begin
                                st <= RX_STOP;
                            end else begin
                                bitn <= bitn + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == CNT_W'(OVS - 1)) begin
                            cnt     <= '0;
                            stop_q  <= rx_s;
                            done_q  <= 1'b1;
                            line_hi <= 1'b0;
                            st      <= RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

    assign frame_done    = done_q;
    assign frame.data    = shreg[DATA_W-1:0];
    assign frame.mpb     = shreg[NBITS-1];
    assign frame.stop_ok = stop_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);                                       // R1

    AST_FALSE_START: assert property (@(posedge clk) disable iff (rst)
        (enable && tick && st == RX_START && cnt == CNT_W'(MID_TICK - 1) && rx_s)
        |=> (st == RX_IDLE && !frame_done));                               // R11

endmodule

// File: rtl/mpr_rx_flags.sv
module mpr_rx_flags
    import mpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_done,
    input  rx_frame_t         frame,
    input  logic              filt_en,
    input  logic              arm_set,
    input  logic              clr_rdrf,
    input  logic              clr_fer,
    input  logic              clr_orer,
    output logic [DATA_W-1:0] rx_data,
    output rx_flags_t         flags,
    output logic              armed
);

    logic [DATA_W-1:0] data_q;
    logic rdrf_q, fer_q, orer_q, mpb_q, armed_q;
    logic filtering, drop, accept, disarm;

    assign filtering = filt_en && armed_q;
    assign drop      = frame_done && filtering && !frame.mpb;
    assign accept    = frame_done && !drop;
    assign disarm    = frame_done && filtering && frame.mpb;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            rdrf_q  <= 1'b0;
            fer_q   <= 1'b0;
            orer_q  <= 1'b0;
            mpb_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (disarm) begin
                armed_q <= 1'b0;
            end else if (arm_set) begin
                armed_q <= 1'b1;
            end

            if (accept) begin
                mpb_q <= frame.mpb;
            end

            if (accept && !frame.stop_ok) begin
                fer_q <= 1'b1;
            end else if (clr_fer) begin
                fer_q <= 1'b0;
            end

            if (accept && rdrf_q) begin
                orer_q <= 1'b1;
            end else if (clr_orer) begin
                orer_q <= 1'b0;
            end

            if (accept && !rdrf_q) begin
                data_q <= frame.data;
            end

            if (accept && !rdrf_q && frame.stop_ok) begin
                rdrf_q <= 1'b1;
            end else if (clr_rdrf) begin
                rdrf_q <= 1'b0;
            end
        end
    end

    assign rx_data    = data_q;
    assign flags.rdrf = rdrf_q;
    assign flags.fer  = fer_q;
    assign flags.orer = orer_q;
    assign flags.mpb  = mpb_q;
    assign armed      = armed_q;

    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst)
        drop |=> (!$rose(rdrf_q) && !$rose(fer_q) && !$rose(orer_q)
                  && $stable(data_q)));                                    // R3

    AST_MPB_DISARM: assert property (@(posedge clk) disable iff (rst)
        (frame_done && filt_en && armed_q && frame.mpb) |=> (!armed_q && mpb_q)); // R4

    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (accept && rdrf_q) |=> (orer_q && $stable(data_q)));               // R7

    AST_FER_NO_RDRF: assert property (@(posedge clk) disable iff (rst)
        (accept && !rdrf_q && !frame.stop_ok) |=> (fer_q && !rdrf_q));     // R6

endmodule

// File: rtl/mpr_serial_rx.sv
module mpr_serial_rx
    import mpr_pkg::*;
#(
    parameter int BAUD_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              async_en,
    input  logic              mp_en,
    input  logic              arm_set,
    input  logic [1:0]        clk_sel,
    input  logic              rx_irq_en,
    input  logic              clr_rdrf,
    input  logic              clr_fer,
    input  logic              clr_orer,
    input  logic              rx,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rdrf,
    output logic              fer,
    output logic              orer,
    output logic              mpb,
    output logic              armed,
    output logic              rxi_irq,
    output logic              eri_irq
);

    logic      tick;
    logic      frame_done;
    rx_frame_t frame;
    rx_flags_t flags;

    mpr_tick_src #(.BAUD_DIV(BAUD_DIV)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .clk_sel (clk_sel),
        .sck_in  (sck_in),
        .tick    (tick),
        .sck_out (sck_out),
        .sck_oe  (sck_oe)
    );

    mpr_rx_core u_core (
        .clk        (clk),
        .rst        (rst),
        .enable     (async_en),
        .tick       (tick),
        .rx         (rx),
        .frame_done (frame_done),
        .frame      (frame)
    );

    mpr_rx_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .frame      (frame),
        .filt_en    (mp_en && async_en),
        .arm_set    (arm_set),
        .clr_rdrf   (clr_rdrf),
        .clr_fer    (clr_fer),
        .clr_orer   (clr_orer),
        .rx_data    (rx_data),
        .flags      (flags),
        .armed      (armed)
    );

    assign rdrf    = flags.rdrf;
    assign fer     = flags.fer;
    assign orer    = flags.orer;
    assign mpb     = flags.mpb;
    assign rxi_irq = rx_irq_en && flags.rdrf;
    assign eri_irq = rx_irq_en && (flags.fer || flags.orer);

endmodule

// File: tb/tb_mpr_serial_rx.sv
module tb_mpr_serial_rx;

    localparam int BD      = 4;
    localparam int BIT_INT = BD * 16;
    localparam int BIT_EXT = 8 * 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst, async_en, mp_en, arm_set, rx_irq_en;
    logic       clr_rdrf, clr_fer, clr_orer, rx, sck_in;
    logic [1:0] clk_sel;
    logic       sck_out, sck_oe, rdrf, fer, orer, mpb, armed, rxi_irq, eri_irq;
    logic [7:0] rx_data;
    logic       ext_run;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] m_data;
    logic m_rdrf, m_fer, m_orer, m_mpb, m_armed;

    mpr_serial_rx #(.BAUD_DIV(BD)) dut (
        .clk(clk), .rst(rst), .async_en(async_en), .mp_en(mp_en),
        .arm_set(arm_set), .clk_sel(clk_sel), .rx_irq_en(rx_irq_en),
        .clr_rdrf(clr_rdrf), .clr_fer(clr_fer), .clr_orer(clr_orer),
        .rx(rx), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .rx_data(rx_data), .rdrf(rdrf), .fer(fer), .orer(orer), .mpb(mpb),
        .armed(armed), .rxi_irq(rxi_irq), .eri_irq(eri_irq)
    );

    // external 16x clock: one rising edge every 8 clocks
    initial begin
        int ph;
        ph = 0;
        sck_in = 1'b0;
        forever begin
            @(negedge clk);
            if (ext_run) begin
                ph = ph + 1;
                if (ph == 4) begin
                    sck_in = ~sck_in;
                    ph = 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input string nm,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual %h expected %h", tag, nm, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "rx_data", rx_data, m_data);
        chk(tag, "rdrf", {7'd0, rdrf}, {7'd0, m_rdrf});
        chk(tag, "fer", {7'd0, fer}, {7'd0, m_fer});
        chk(tag, "orer", {7'd0, orer}, {7'd0, m_orer});
        chk(tag, "mpb", {7'd0, mpb}, {7'd0, m_mpb});
        chk(tag, "armed", {7'd0, armed}, {7'd0, m_armed});
        chk("R5", "rxi_irq", {7'd0, rxi_irq}, {7'd0, rx_irq_en & m_rdrf});
        chk("R5", "eri_irq", {7'd0, eri_irq}, {7'd0, rx_irq_en & (m_fer | m_orer)});
    endtask

    function automatic logic filt_on();
        return mp_en && async_en && m_armed;
    endfunction

    // expected-state update for one complete frame
    task automatic model_frame(input logic [7:0] d, input logic m, input logic s);
        if (!async_en) return;
        if (filt_on() && !m) return;
        if (filt_on() && m) m_armed = 1'b0;
        m_mpb = m;
        if (!s) m_fer = 1'b1;
        if (m_rdrf) begin
            m_orer = 1'b1;
        end else begin
            m_data = d;
            if (s) m_rdrf = 1'b1;
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic m,
                              input logic s, input int blen);
        logic [10:0] bits;
        bits = {s, m, d, 1'b0};
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            rx = bits[i];
            repeat (blen - 1) @(negedge clk);
        end
        @(negedge clk);
        rx = 1'b1;
        repeat (blen * 2) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] d, input logic m,
                         input logic s, input string tag);
        send_frame(d, m, s, BIT_INT);
        model_frame(d, m, s);
        check_all(tag);
    endtask

    task automatic do_clear(input logic r, input logic f, input logic o);
        @(negedge clk);
        clr_rdrf = r; clr_fer = f; clr_orer = o;
        @(negedge clk);
        clr_rdrf = 1'b0; clr_fer = 1'b0; clr_orer = 1'b0;
        if (r) m_rdrf = 1'b0;
        if (f) m_fer = 1'b0;
        if (o) m_orer = 1'b0;
    endtask

    task automatic do_arm();
        @(negedge clk);
        arm_set = 1'b1;
        @(negedge clk);
        arm_set = 1'b0;
        m_armed = 1'b1;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        int edges;
        logic prev;
        void'($urandom(32'd4711));
        rst = 1'b1; async_en = 1'b1; mp_en = 1'b0; arm_set = 1'b0;
        rx_irq_en = 1'b0; clr_rdrf = 1'b0; clr_fer = 1'b0; clr_orer = 1'b0;
        rx = 1'b1; clk_sel = 2'b00; ext_run = 1'b0;
        m_data = 8'h00; m_rdrf = 0; m_fer = 0; m_orer = 0; m_mpb = 0; m_armed = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (BIT_INT) @(negedge clk);

        // R12 reset state
        check_all("R12");
        chk("R12", "sck_oe", {7'd0, sck_oe}, 8'd0);

        // R1 basic reception, R5 interrupts
        rx_irq_en = 1'b1;
        frame(8'hA5, 1'b0, 1'b1, "R1");
        // R7 overrun keeps data
        frame(8'h3C, 1'b1, 1'b1, "R7");
        // R8 clears act independently
        do_clear(1'b1, 1'b0, 1'b0);
        check_all("R8");
        do_clear(1'b0, 1'b0, 1'b1);
        check_all("R8");
        // R6 low stop bit
        frame(8'h5E, 1'b0, 1'b0, "R6");
        frame(8'h61, 1'b0, 1'b1, "R6");
        do_clear(1'b1, 1'b1, 1'b0);
        check_all("R8");

        // R1 receiver idle when async disabled
        async_en = 1'b0;
        frame(8'hFF, 1'b1, 1'b1, "R1");
        async_en = 1'b1;

        // R3 armed filter drops MPB=0, even with low stop
        mp_en = 1'b1;
        do_arm();
        check_all("R8");
        frame(8'h11, 1'b0, 1'b1, "R3");
        frame(8'h22, 1'b0, 1'b0, "R3");
        // R4 MPB=1 disarms and is received
        frame(8'h47, 1'b1, 1'b1, "R4");
        do_clear(1'b1, 1'b0, 1'b0);
        frame(8'h48, 1'b0, 1'b1, "R4");
        do_clear(1'b1, 1'b0, 1'b0);

        // R2 filter inactive without multiprocessor mode
        mp_en = 1'b0;
        do_arm();
        frame(8'h99, 1'b0, 1'b1, "R2");
        do_clear(1'b1, 1'b0, 1'b0);
        mp_en = 1'b1;
        frame(8'h9A, 1'b0, 1'b1, "R2");

        // R11 false start
        @(negedge clk);
        rx = 1'b0;
        repeat (3 * BD) @(negedge clk);
        rx = 1'b1;
        repeat (12 * BIT_INT) @(negedge clk);
        check_all("R11");
        mp_en = 1'b0;
        frame(8'hC3, 1'b0, 1'b1, "R11");
        do_clear(1'b1, 1'b0, 1'b0);

        // R9 pin modes
        chk("R9", "sck_oe", {7'd0, sck_oe}, 8'd0);
        chk("R9", "sck_out", {7'd0, sck_out}, 8'd0);
        clk_sel = 2'b01;
        repeat (BIT_INT) @(negedge clk);
        chk("R9", "sck_oe", {7'd0, sck_oe}, 8'd1);
        edges = 0;
        prev = sck_out;
        repeat (16 * BIT_INT) begin
            @(negedge clk);
            if (sck_out && !prev) edges++;
            prev = sck_out;
        end
        chk("R9", "sck_edges_in_16_bits", 8'(edges), (edges >= 15 && edges <= 17) ? 8'(edges) : 8'd16);
        frame(8'h6B, 1'b1, 1'b1, "R9");
        do_clear(1'b1, 1'b0, 1'b0);

        // R10 external tick source
        clk_sel = 2'b10;
        ext_run = 1'b1;
        repeat (BIT_EXT) @(negedge clk);
        chk("R10", "sck_oe", {7'd0, sck_oe}, 8'd0);
        send_frame(8'hD2, 1'b0, 1'b1, BIT_EXT);
        model_frame(8'hD2, 1'b0, 1'b1);
        check_all("R10");
        do_clear(1'b1, 1'b0, 1'b0);
        clk_sel = 2'b11;
        send_frame(8'h2D, 1'b1, 1'b1, BIT_EXT);
        model_frame(8'h2D, 1'b1, 1'b1);
        check_all("R10");
        do_clear(1'b1, 1'b0, 1'b0);
        ext_run = 1'b0;
        clk_sel = 2'b00;
        repeat (BIT_INT) @(negedge clk);

        // random mix of frames, arms, clears and modes
        for (int k = 0; k < 50; k++) begin
            logic [7:0] d;
            logic m, s;
            d = 8'($urandom);
            m = 1'($urandom % 2);
            s = ($urandom % 5) != 0;
            mp_en = ($urandom % 4) != 0;
            rx_irq_en = 1'($urandom % 2);
            if ($urandom % 4 == 0) do_arm();
            if ($urandom % 2 == 0)
                do_clear(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
            frame(d, m, s, "R3/R4 random");
        end

        summary();
        $finish;
    end

endmodule